// File: doc/BRIEF.md
# Isochronous Cycle Event Monitor

This block watches the local isochronous cycle timer of a serial bus link together with the bus events the link reports. From these inputs it raises single-clock event pulses for the interrupt sources tied to cycle timing. The pulses cover five events: a new isochronous cycle, a change of the seconds counter's top bit, a received cycle start whose time fields disagree with the local timer, a lost or predicted-lost cycle, and an overrun of the cycle-master period. The block does not parse packets and does not contain the timer counter.

The timer arrives as its upper 20 bits. Bits 19:13 of `cyc_time_i` hold the seconds field (timer bits 31–25) and bits 12:0 hold the cycle count (timer bits 24–12). The lost-cycle tracker reports a lost cycle in two ways. It reports one after the fact, when two new cycles pass with no cycle start between them. It also predicts one from the order of gaps. A cycle-master guard measures the time from sending a cycle start to the end of the next subaction gap. On an overrun it withdraws cycle-master status and keeps it withdrawn until the request is dropped and raised again.

Every output is a register. A result appears in the cycle after the clock edge that samples its cause.

Top module: `cyc_event_mon`

## Requirements
- R1: `evt_new_cycle_o` pulses for one cycle after an edge at which bit 0 of the count field (`cyc_time_i[0]`) differs from its value at the previous edge.
- R2: `evt_sec64_o` pulses after an edge at which seconds bit 6 (`cyc_time_i[19]`) differs from its previous value. Changes to other seconds bits give no pulse.
- R3: When `rx_start_i` is sampled, `evt_inconsist_o` pulses if `rx_sec_i` differs from the local seconds or `rx_cnt_i` differs from the local count. It stays low when both match.
- R4: `evt_lost_o` pulses when a new cycle is detected and no cycle start (`rx_start_i` or `tx_start_i`) was sampled since the previous new cycle.
- R5: After a new cycle, if the first subaction gap is followed by another gap before any cycle start, `evt_lost_o` pulses at that second gap.
- R6: After a new cycle, an arbitration reset gap seen before any cycle start makes `evt_lost_o` pulse.
- R7: `evt_lost_o` pulses at most once between two new cycles, even when a predictive and an after-the-fact condition both occur.
- R8: With cycle master active, `evt_too_long_o` pulses if no subaction gap is sampled in the TICKS edges after the edge sampling `tx_start_i`. `cycle_master_o` falls at that same edge.
- R9: A subaction gap sampled within those TICKS edges ends the measurement with no event. A `tx_start_i` while cycle master is inactive starts no measurement.
- R10: `cycle_master_o` follows `master_req_i` one edge later. After an overrun it stays low until `master_req_i` has been sampled low.
- R11: After reset all event outputs and `cycle_master_o` are 0, and `evt_lost_o` and `evt_too_long_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cyc_time_i | input | 20 | Local timer seconds [19:13] and count [12:0] |
| rx_start_i | input | 1 | Cycle start received strobe |
| rx_sec_i | input | 7 | Seconds field of the received cycle start |
| rx_cnt_i | input | 13 | Count field of the received cycle start |
| tx_start_i | input | 1 | Cycle start sent strobe |
| sub_gap_i | input | 1 | Subaction gap strobe |
| arb_gap_i | input | 1 | Arbitration reset gap strobe |
| master_req_i | input | 1 | Requested cycle-master mode |
| evt_new_cycle_o | output | 1 | New cycle event pulse |
| evt_sec64_o | output | 1 | Seconds bit 6 change pulse |
| evt_inconsist_o | output | 1 | Inconsistent cycle start pulse |
| evt_lost_o | output | 1 | Lost cycle pulse |
| evt_too_long_o | output | 1 | Cycle master overrun pulse |
| cycle_master_o | output | 1 | Effective cycle-master bit |

## Verification
Each event is a register updated at the edge that samples its cause. The bench therefore drives a stimulus after a falling edge, waits for the next rising edge and reads the outputs one time unit later, and the following idle step confirms the pulse is gone. The overrun is due exactly TICKS edges after the edge that samples the sent start. The bench checks that no event appears after TICKS-1 edges and that the event appears on edge TICKS. It also checks that a gap placed on edge TICKS still counts as in time.

// File: rtl/cyc_mon_pkg.sv
package cyc_mon_pkg;
    localparam int SEC_W = 7;
    localparam int CNT_W = 13;
    localparam int TIME_W = SEC_W + CNT_W;
    localparam int SEC64_BIT = 6;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [CNT_W-1:0] cnt;
    } cyc_time_t;

    typedef enum logic [1:0] {
        LS_IDLE = 2'd0,
        LS_WAIT = 2'd1,
        LS_GAP  = 2'd2,
        LS_DONE = 2'd3
    } lost_state_t;

    function automatic cyc_time_t to_time(input logic [TIME_W-1:0] raw);
        return cyc_time_t'(raw);
    endfunction

    function automatic logic time_differs(input cyc_time_t a,
                                          input logic [SEC_W-1:0] s,
                                          input logic [CNT_W-1:0] c);
        return (a.sec != s) || (a.cnt != c);
    endfunction
endpackage

// File: rtl/cyc_time_edges.sv
module cyc_time_edges
    import cyc_mon_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  cyc_time_t now_i,
    output logic      new_cycle_now_o,
    output logic      evt_new_cycle_o,
    output logic      evt_sec64_o
);
    cyc_time_t prev_q;
    logic      primed_q;
    logic      sec64_now;

    assign new_cycle_now_o = primed_q && (now_i.cnt[0] != prev_q.cnt[0]);
    assign sec64_now       = primed_q && (now_i.sec[SEC64_BIT] != prev_q.sec[SEC64_BIT]);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            prev_q          <= '0;
            primed_q        <= 1'b0;
            evt_new_cycle_o <= 1'b0;
            evt_sec64_o     <= 1'b0;
        end else begin
            prev_q          <= now_i;
            primed_q        <= 1'b1;
            evt_new_cycle_o <= new_cycle_now;
            evt_sec64_o     <= sec64_now;
        end
    end

    logic new_cycle_now;
    assign new_cycle_now = new_cycle_now_o;
endmodule

// File: rtl/cyc_start_check.sv
module cyc_start_check
    import cyc_mon_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  cyc_time_t        now_i,
    input  logic             rx_start_i,
    input  logic [SEC_W-1:0] rx_sec_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    output logic             evt_inconsist_o
);
    logic mismatch;
    assign mismatch = rx_start_i && time_differs(now_i, rx_sec_i, rx_cnt_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) evt_inconsist_o <= 1'b0;
        else       evt_inconsist_o <= mismatch;
    end
endmodule

// File: rtl/cyc_lost_track.sv
module cyc_lost_track
    import cyc_mon_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic new_cycle_i,
    input  logic start_seen_i,
    input  logic sub_gap_i,
    input  logic arb_gap_i,
    output logic evt_lost_o
);
    lost_state_t state_q, state_d;
    logic        lost_d;

    always_comb begin
        state_d = state_q;
        lost_d  = 1'b0;
        if (new_cycle_i) begin
            // after-the-fact: a whole period passed without any start
            lost_d  = ((state_q == LS_WAIT) || (state_q == LS_GAP)) && !start_seen_i;
            state_d = LS_WAIT;
        end else if (start_seen_i) begin
            state_d = LS_IDLE;
        end else begin
            unique case (state_q)
                LS_WAIT: begin
                    if (arb_gap_i) begin
                        lost_d  = 1'b1;
                        state_d = LS_DONE;
                    end else if (sub_gap_i) begin
                        state_d = LS_GAP;
                    end
                end
                LS_GAP: begin
                    if (arb_gap_i || sub_gap_i) begin
                        lost_d  = 1'b1;
                        state_d = LS_DONE;
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q    <= LS_IDLE;
            evt_lost_o <= 1'b0;
        end else begin
            state_q    <= state_d;
            evt_lost_o <= lost_d;
        end
    end
endmodule

// File: rtl/cyc_master_guard.sv
module cyc_master_guard #(
    parameter int TICKS = 3072
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic master_req_i,
    input  logic tx_start_i,
    input  logic sub_gap_i,
    output logic cycle_master_o,
    output logic evt_too_long_o
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          blocked_q;
    logic          fire;
    logic          blocked_d;

    assign fire      = run_q && cycle_master_o && !sub_gap_i && (cnt_q == LAST);
    assign blocked_d = fire ? 1'b1 : (master_req_i ? blocked_q : 1'b0);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q          <= '0;
            run_q          <= 1'b0;
            blocked_q      <= 1'b0;
            cycle_master_o <= 1'b0;
            evt_too_long_o <= 1'b0;
        end else begin
            blocked_q      <= blocked_d;
            cycle_master_o <= master_req_i && !blocked_d;
            evt_too_long_o <= fire;
            if (fire || !cycle_master_o) begin
                run_q <= 1'b0;
            end else if (tx_start_i) begin
                run_q <= 1'b1;
                cnt_q <= '0;
            end else if (run_q && sub_gap_i) begin
                run_q <= 1'b0;
            end else if (run_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cyc_event_mon.sv
module cyc_event_mon
    import cyc_mon_pkg::*;
#(
    parameter int TICKS = 3072
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [TIME_W-1:0] cyc_time_i,
    input  logic              rx_start_i,
    input  logic [SEC_W-1:0]  rx_sec_i,
    input  logic [CNT_W-1:0]  rx_cnt_i,
    input  logic              tx_start_i,
    input  logic              sub_gap_i,
    input  logic              arb_gap_i,
    input  logic              master_req_i,
    output logic              evt_new_cycle_o,
    output logic              evt_sec64_o,
    output logic              evt_inconsist_o,
    output logic              evt_lost_o,
    output logic              evt_too_long_o,
    output logic              cycle_master_o
);
    cyc_time_t now;
    logic      new_cycle_now;

    assign now = to_time(cyc_time_i);

    cyc_time_edges u_edges (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .now_i           (now),
        .new_cycle_now_o (new_cycle_now),
        .evt_new_cycle_o (evt_new_cycle_o),
        .evt_sec64_o     (evt_sec64_o)
    );

    cyc_start_check u_check (
        .clk_i           (clk_i),
        .rst_i           (rst_i),
        .now_i           (now),
        .rx_start_i      (rx_start_i),
        .rx_sec_i        (rx_sec_i),
        .rx_cnt_i        (rx_cnt_i),
        .evt_inconsist_o (evt_inconsist_o)
    );

    cyc_lost_track u_lost (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .new_cycle_i  (new_cycle_now),
        .start_seen_i (rx_start_i | tx_start_i),
        .sub_gap_i    (sub_gap_i),
        .arb_gap_i    (arb_gap_i),
        .evt_lost_o   (evt_lost_o)
    );

    cyc_master_guard #(.TICKS(TICKS)) u_guard (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .master_req_i   (master_req_i),
        .tx_start_i     (tx_start_i),
        .sub_gap_i      (sub_gap_i),
        .cycle_master_o (cycle_master_o),
        .evt_too_long_o (evt_too_long_o)
    );
endmodule

// File: rtl/cyc_event_mon_chk.sv
module cyc_event_mon_chk
    import cyc_mon_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [TIME_W-1:0] cyc_time_i,
    input logic              rx_start_i,
    input logic              tx_start_i,
    input logic              master_req_i,
    input logic              evt_inconsist_o,
    input logic              evt_lost_o,
    input logic              evt_too_long_o,
    input logic              cycle_master_o
);
    p_inconsist_needs_rx_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_inconsist_o |-> $past(rx_start_i));

    p_lost_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_lost_o |=> !evt_lost_o);

    p_overrun_drops_master_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_too_long_o |-> !cycle_master_o);

    p_overrun_needs_master_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_too_long_o |-> $past(cycle_master_o));

    p_master_follows_req_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        cycle_master_o |-> $past(master_req_i));

    p_overrun_single_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        evt_too_long_o |=> !evt_too_long_o);

    always_comb begin
        if (!rst_i) begin
            a_time_known_r1: assert (!$isunknown(cyc_time_i));
        end
    end

    logic unused_ok;
    assign unused_ok = tx_start_i;
endmodule

bind cyc_event_mon cyc_event_mon_chk u_chk (
    .clk_i           (clk_i),
    .rst_i           (rst_i),
    .cyc_time_i      (cyc_time_i),
    .rx_start_i      (rx_start_i),
    .tx_start_i      (tx_start_i),
    .master_req_i    (master_req_i),
    .evt_inconsist_o (evt_inconsist_o),
    .evt_lost_o      (evt_lost_o),
    .evt_too_long_o  (evt_too_long_o),
    .cycle_master_o  (cycle_master_o)
);

// File: tb/cyc_event_mon_tb.sv
`timescale 1ns/1ps
module cyc_event_mon_tb;
    localparam int TICKS = 3072;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  sec = '0;
    logic [12:0] cnt = '0;
    logic        rx_start = 1'b0, tx_start = 1'b0, sub_gap = 1'b0, arb_gap = 1'b0;
    logic [6:0]  rx_sec = '0;
    logic [12:0] rx_cnt = '0;
    logic        master_req = 1'b0;
    logic        e_new, e_s64, e_inc, e_lost, e_long, master;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    cyc_event_mon #(.TICKS(TICKS)) u_dut (
        .clk_i(clk), .rst_i(rst), .cyc_time_i({sec, cnt}),
        .rx_start_i(rx_start), .rx_sec_i(rx_sec), .rx_cnt_i(rx_cnt),
        .tx_start_i(tx_start), .sub_gap_i(sub_gap), .arb_gap_i(arb_gap),
        .master_req_i(master_req),
        .evt_new_cycle_o(e_new), .evt_sec64_o(e_s64), .evt_inconsist_o(e_inc),
        .evt_lost_o(e_lost), .evt_too_long_o(e_long), .cycle_master_o(master)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // one edge of stimulus; outputs read 1 ns after the rising edge
    task automatic step(input logic rx, input logic tx, input logic gap,
                        input logic arb, input logic bump);
        @(negedge clk);
        rx_start = rx; tx_start = tx; sub_gap = gap; arb_gap = arb;
        rx_sec = sec; rx_cnt = cnt;
        if (bump) cnt = cnt + 13'd1;
        @(posedge clk);
        #1;
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0); endtask
    task automatic settle(); step(1, 0, 0, 0, 0); idle(); endtask

    task automatic t_reset();
        check("R11 reset new", e_new, 0);
        check("R11 reset lost", e_lost, 0);
        check("R11 reset long", e_long, 0);
        check("R11 reset master", master, 0);
    endtask

    task automatic t_new_cycle();
        step(0, 0, 0, 0, 1);
        check("R1 toggle pulse", e_new, 1);
        idle();
        check("R1 one cycle", e_new, 0);
        settle();
    endtask

    task automatic t_sec64();
        @(negedge clk); sec = 7'h3F; @(posedge clk); #1;
        check("R2 low bits no pulse", e_s64, 0);
        @(negedge clk); sec = 7'h40; @(posedge clk); #1;
        check("R2 bit6 pulse", e_s64, 1);
        idle();
        check("R2 one cycle", e_s64, 0);
    endtask

    task automatic t_inconsist();
        step(1, 0, 0, 0, 0);
        check("R3 match quiet", e_inc, 0);
        @(negedge clk); rx_start = 1; rx_sec = sec; rx_cnt = cnt ^ 13'h10;
        @(posedge clk); #1;
        check("R3 count differs", e_inc, 1);
        @(negedge clk); rx_start = 1; rx_sec = sec ^ 7'h1; rx_cnt = cnt;
        @(posedge clk); #1;
        check("R3 seconds differs", e_inc, 1);
        idle();
        check("R3 cleared", e_inc, 0);
    endtask

    task automatic t_lost_late();
        settle();
        step(0, 0, 0, 0, 1);
        check("R4 first cycle quiet", e_lost, 0);
        idle();
        step(0, 0, 0, 0, 1);
        check("R4 missed start", e_lost, 1);
        idle();
        check("R11 lost one cycle", e_lost, 0);
        settle();
    endtask

    task automatic t_lost_gap();
        settle();
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        check("R5 first gap quiet", e_lost, 0);
        step(0, 0, 1, 0, 0);
        check("R5 second gap", e_lost, 1);
        step(0, 0, 0, 0, 1);
        check("R7 no repeat", e_lost, 0);
        settle();
    endtask

    task automatic t_lost_arb();
        settle();
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 0);
        check("R6 arb gap", e_lost, 1);
        settle();
    endtask

    task automatic t_lost_ok();
        settle();
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 0, 0);
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        check("R4 start seen quiet", e_lost, 0);
        settle();
    endtask

    task automatic t_master();
        step(0, 1, 0, 0, 0);
        idle();
        check("R9 no run when off", e_long, 0);
        @(negedge clk); master_req = 1; @(posedge clk); #1;
        check("R10 master follows", master, 1);
        step(0, 1, 0, 0, 0);
        for (int i = 1; i < TICKS; i++) idle();
        check("R9 not yet due", e_long, 0);
        step(0, 0, 1, 0, 0);
        check("R9 gap on last edge", e_long, 0);
        idle();
        check("R9 master kept", master, 1);
        step(0, 1, 0, 0, 0);
        for (int i = 1; i < TICKS; i++) idle();
        check("R8 edge before", e_long, 0);
        idle();
        check("R8 overrun", e_long, 1);
        check("R8 master dropped", master, 0);
        idle();
        check("R11 overrun one cycle", e_long, 0);
        check("R10 stays low", master, 0);
        @(negedge clk); master_req = 0; @(posedge clk); #1;
        @(negedge clk); master_req = 1; @(posedge clk); #1;
        check("R10 rearmed", master, 1);
        @(negedge clk); master_req = 0; @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst = 0;
        idle();
        t_new_cycle();
        t_sec64();
        t_inconsist();
        t_lost_late();
        t_lost_gap();
        t_lost_arb();
        t_lost_ok();
        t_master();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule